// File: doc/BRIEF.md
# Overlapped Accumulator Add/Branch Pipeline

This block is the datapath and sequencer of a small 8-bit accumulator machine. It executes two kinds of instruction. The first adds an immediate operand and the carry to the accumulator. The second branches on a negative result. It builds every stage from rising-edge flip-flops. Fetch, decode, execution and writeback of neighbouring instructions overlap, so an add costs two cycles of throughput while its work spans five.

The address output is a multiplexer and holds no register. In normal operation it follows the program counter. During a taken branch it shows the branch target instead, so fetching restarts in that same cycle. Program memory is synchronous: a byte requested in one cycle appears on the read-data input in the next. The accumulator and the flags are brought out so that a neighbouring block can use the results.

Top module: `ovl_acc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the address output equals the start address (default 0x0010), and the accumulator and all flags read zero.
- R2: In every cycle that is not a branch-decision cycle, the address equals the program counter, and the counter advances by one at the next edge. An opcode is decoded in the cycle after its address was presented.
- R3: Opcode 0xA1 is a two-byte add-immediate. Its operand arrives in the execute cycle and feeds the adder directly, together with the accumulator and the carry flag. The address of the next opcode is presented in that same cycle, so the add costs two cycles (for example 0x41 + 0x1F + carry 1 = 0x61).
- R4: The flags are N (flags bit 3, the result's sign), V (bit 2, signed overflow), Z (bit 1, the result is zero) and C (bit 0, carry out). All four load at the end of the execute cycle, are visible from the next cycle on, and change at no other time.
- R5: The accumulator takes the registered sum one cycle after the flags, while the next instruction is being decoded. Back-to-back adds still use the correct accumulator.
- R6: Opcode 0xB2 is a two-byte branch on N. When N is 1, the decision cycle puts on the address output the address after the offset byte plus the sign-extended offset, and fetching continues from there.
- R7: When N is 0, the decision cycle presents the address after the offset byte, and execution continues in sequence.
- R8: A branch that directly follows an add decides on the N flag produced by that add.
- R9: Every other opcode is a one-byte no-op. It changes neither the accumulator nor the flags, and the byte after it is decoded as the next opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_o | output | AW (16) | Combinational fetch address |
| rdata_i | input | DW (8) | Byte read from the previous cycle's address |
| acc_o | output | DW (8) | Accumulator |
| flags_o | output | 4 | Flags {N, V, Z, C} |

## Verification
Every address is checked cycle by cycle, so a wrong sequencer state or program counter shows on the address output at once. A decoding error appears within one cycle: a missed operand skip or a misread branch offset puts a wrong address on the bus in the next cycle. Errors in the adder or the flags appear on the flags output one cycle after the execute cycle and on the accumulator one cycle after that. A wrong flag also shifts the address of the next branch decision.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_DECODE = 2'd1,
      ST_EXEC   = 2'd2,
      ST_BRANCH = 2'd3
   } ovl_state_e;

   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } ovl_flags_t;
endpackage

// File: rtl/ovl_alu.sv
module ovl_alu #(
   parameter int DW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [DW-1:0]       opa,
   input  logic [DW-1:0]       opb,
   output logic [DW-1:0]       res_q,
   output ovl_pkg::ovl_flags_t flags_q
);
   localparam int MSB = DW - 1;

   logic [DW:0]   sum_w;
   logic [DW-1:0] res_w;
   logic          ovf_w;

   // add with the carry flag; there is no register in front of the adder
   assign sum_w = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, flags_q.c};
   assign res_w = sum_w[DW-1:0];
   assign ovf_w = (opa[MSB] == opb[MSB]) && (res_w[MSB] != opa[MSB]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q   <= '0;
         flags_q <= '0;
      end else if (load) begin
         res_q     <= res_w;
         flags_q.n <= res_w[MSB];
         flags_q.v <= ovf_w;
         flags_q.z <= (res_w == '0);
         flags_q.c <= sum_w[DW];
      end
   end
endmodule

// File: rtl/ovl_seq.sv
module ovl_seq #(
   parameter int            AW     = 16,
   parameter int            DW     = 8,
   parameter logic [AW-1:0] START  = 16'h0010,
   parameter logic [DW-1:0] OP_ADD = 8'hA1,
   parameter logic [DW-1:0] OP_BRN = 8'hB2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DW-1:0]       rdata,
   input  logic                neg,
   output logic [AW-1:0]       addr,
   output ovl_pkg::ovl_state_e st_q
);
   import ovl_pkg::*;

   localparam logic [AW-1:0] ONE = AW'(1);

   ovl_state_e    st_d;
   logic [AW-1:0] pc_q, pc_d, off_ext, tgt;

   if (AW > DW) begin : g_sext
      assign off_ext = {{(AW-DW){rdata[DW-1]}}, rdata};
   end else begin : g_same
      assign off_ext = rdata[AW-1:0];
   end

   assign tgt = pc_q + off_ext;

   always_comb begin
      addr = pc_q;
      pc_d = pc_q + ONE;
      st_d = ST_DECODE;
      case (st_q)
         ST_FETCH:  st_d = ST_DECODE;
         ST_DECODE: begin
            if (rdata == OP_ADD)      st_d = ST_EXEC;
            else if (rdata == OP_BRN) st_d = ST_BRANCH;
            else                      st_d = ST_DECODE;
         end
         ST_EXEC:   st_d = ST_DECODE;
         ST_BRANCH: begin
            if (neg) begin
               addr = tgt;
               pc_d = tgt + ONE;
            end
         end
         default:   st_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= START;
         st_q <= ST_FETCH;
      end else begin
         pc_q <= pc_d;
         st_q <= st_d;
      end
   end
endmodule

// File: rtl/ovl_acc_core.sv
module ovl_acc_core #(
   parameter int            AW     = 16,
   parameter int            DW     = 8,
   parameter logic [AW-1:0] START  = 16'h0010,
   parameter logic [DW-1:0] OP_ADD = 8'hA1,
   parameter logic [DW-1:0] OP_BRN = 8'hB2
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] addr_o,
   input  logic [DW-1:0] rdata_i,
   output logic [DW-1:0] acc_o,
   output logic [3:0]    flags_o
);
   import ovl_pkg::*;

   if (DW < 4) begin : g_bad_dw
      $error("ovl_acc_core: DW must be at least 4");
   end
   if (AW < DW) begin : g_bad_aw
      $error("ovl_acc_core: AW must not be narrower than DW");
   end
   if (OP_ADD == OP_BRN) begin : g_bad_op
      $error("ovl_acc_core: opcodes must differ");
   end

   ovl_state_e    st;
   ovl_flags_t    flags_q;
   logic [DW-1:0] alu_q, acc_q;
   logic          wb_pend;

   ovl_seq #(
      .AW(AW), .DW(DW), .START(START), .OP_ADD(OP_ADD), .OP_BRN(OP_BRN)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .rdata (rdata_i),
      .neg   (flags_q.n),
      .addr  (addr_o),
      .st_q  (st)
   );

   ovl_alu #(.DW(DW)) u_alu (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (st == ST_EXEC),
      .opa     (acc_q),
      .opb     (rdata_i),
      .res_q   (alu_q),
      .flags_q (flags_q)
   );

   // writeback one cycle after the ALU register loads
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_pend <= 1'b0;
         acc_q   <= '0;
      end else begin
         wb_pend <= (st == ST_EXEC);
         if (wb_pend) acc_q <= alu_q;
      end
   end

   assign acc_o   = acc_q;
   assign flags_o = flags_q;
endmodule

// File: rtl/ovl_acc_core_chk.sv
module ovl_acc_core_chk #(
   parameter int            AW     = 16,
   parameter int            DW     = 8,
   parameter logic [DW-1:0] OP_ADD = 8'hA1
) (
   input logic                clk,
   input logic                rst_n,
   input ovl_pkg::ovl_state_e st,
   input logic [AW-1:0]       addr,
   input logic [DW-1:0]       rdata,
   input logic [DW-1:0]       acc,
   input logic [DW-1:0]       alu_q,
   input logic                wb_pend,
   input logic [3:0]          flags
);
   import ovl_pkg::*;

   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_BRANCH) |=> (st == ST_BRANCH || addr == $past(addr) + AW'(1)));

   p_add_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DECODE && rdata == OP_ADD) |=> (st == ST_EXEC));

   p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_EXEC) |=> $stable(flags));

   p_writeback_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_pend |=> (acc == $past(alu_q)));

   p_branch_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BRANCH) |=> (st == ST_DECODE));

   p_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BRANCH && !flags[3]) |-> (addr == $past(addr) + AW'(1)));
endmodule

bind ovl_acc_core ovl_acc_core_chk #(.AW(AW), .DW(DW), .OP_ADD(OP_ADD)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .st      (st),
   .addr    (addr_o),
   .rdata   (rdata_i),
   .acc     (acc_o),
   .alu_q   (alu_q),
   .wb_pend (wb_pend),
   .flags   (flags_o)
);

// File: tb/ovl_acc_core_test.sv
module ovl_acc_core_test;
   localparam logic [15:0] START = 16'h0010;
   localparam logic [7:0]  ADD   = 8'hA1;
   localparam logic [7:0]  BRN   = 8'hB2;

   typedef struct {
      logic [15:0] a;
      logic [7:0]  acc;
      logic [3:0]  f;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr;
   logic [7:0]  rdata = 8'h00;
   logic [7:0]  acc;
   logic [3:0]  flags;
   logic [7:0]  mem [256];
   exp_t        q[$];
   exp_t        e;
   logic        mon_en = 1'b0;
   logic        done = 1'b0;
   int          checks = 0;
   int          fails = 0;

   int          cyc, flg_at, acc_at;
   logic [7:0]  acc_vis, acc_new, isa_acc;
   logic [3:0]  flg_vis, flg_new, isa_f;

   ovl_acc_core uut (
      .clk(clk), .rst_n(rst_n), .addr_o(addr), .rdata_i(rdata),
      .acc_o(acc), .flags_o(flags)
   );

   always #2 clk = ~clk;

   always @(posedge clk) rdata <= mem[addr[7:0]];

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pop one expected cycle per clock
   always @(negedge clk) begin
      if (mon_en && q.size() > 0) begin
         e = q.pop_front();
         chk(e.tag, addr, e.a);
         chk("R5 accumulator", {8'h00, acc}, {8'h00, e.acc});
         chk("R4 flags", {12'h000, flags}, {12'h000, e.f});
      end
   end

   task automatic emit(input logic [15:0] a, input string tag);
      exp_t x;
      if (cyc >= flg_at) flg_vis = flg_new;
      if (cyc >= acc_at) acc_vis = acc_new;
      x.a = a; x.acc = acc_vis; x.f = flg_vis; x.tag = tag;
      q.push_back(x);
      cyc++;
   endtask

   // instruction-level model producing the expected per-cycle trace
   task automatic gen(input int ncyc);
      logic [15:0] pc, tgt;
      logic [7:0]  opnd, op;
      logic [8:0]  s;
      logic        v, prev_add;
      string       tg;
      cyc = 0; flg_at = 1 << 30; acc_at = 1 << 30;
      acc_vis = 8'h00; flg_vis = 4'h0; isa_acc = 8'h00; isa_f = 4'h0;
      pc = START; prev_add = 1'b0;
      emit(START, "R1 first fetch");
      while (cyc < ncyc) begin
         op = mem[pc[7:0]];
         if (op == ADD) begin
            emit(pc + 16'd1, "R2 decode");
            opnd = mem[8'(pc[7:0] + 8'd1)];
            emit(pc + 16'd2, "R3 add next fetch");
            s = {1'b0, isa_acc} + {1'b0, opnd} + {8'h00, isa_f[0]};
            v = (isa_acc[7] == opnd[7]) && (s[7] != isa_acc[7]);
            isa_acc = s[7:0];
            isa_f = {s[7], v, (s[7:0] == 8'h00), s[8]};
            flg_new = isa_f; flg_at = cyc;
            acc_new = isa_acc; acc_at = cyc + 1;
            pc = pc + 16'd2;
            prev_add = 1'b1;
         end else if (op == BRN) begin
            emit(pc + 16'd1, "R2 decode");
            opnd = mem[8'(pc[7:0] + 8'd1)];
            tgt = isa_f[3] ? pc + 16'd2 + {{8{opnd[7]}}, opnd} : pc + 16'd2;
            if (prev_add) tg = "R8 branch after add";
            else if (isa_f[3]) tg = "R6 taken";
            else tg = "R7 not taken";
            emit(tgt, tg);
            pc = tgt;
            prev_add = 1'b0;
         end else begin
            emit(pc + 16'd1, "R9 no-op");
            pc = pc + 16'd1;
            prev_add = 1'b0;
         end
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
   endtask

   task automatic put(input int a, input logic [7:0] b);
      mem[a] = b;
   endtask

   // driver: reset, push expected items, release and wait for the monitor
   task automatic run_prog(input int ncyc);
      mon_en = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset addr", addr, START);
      chk("R1 reset acc", {8'h00, acc}, 16'h0000);
      chk("R1 reset flags", {12'h000, flags}, 16'h0000);
      gen(ncyc);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      mon_en = 1'b1;
      wait (q.size() == 0);
      #1;
      mon_en = 1'b0;
   endtask

   initial begin
      // program 1: carry chain, 0x41+0x1F+1, branches right after adds
      clear_mem();
      put(8'h10, ADD); put(8'h11, 8'hC1);
      put(8'h12, ADD); put(8'h13, 8'h80);
      put(8'h14, ADD); put(8'h15, 8'h1F);
      put(8'h16, BRN); put(8'h17, 8'h04);
      put(8'h18, ADD); put(8'h19, 8'h7F);
      put(8'h1A, BRN); put(8'h1B, 8'hFC);
      run_prog(40);

      // program 2: no-ops, taken and not-taken branches, zero result
      clear_mem();
      put(8'h10, ADD); put(8'h11, 8'h80);
      put(8'h12, 8'h07);
      put(8'h13, BRN); put(8'h14, 8'h03);
      put(8'h15, ADD); put(8'h16, 8'hFF); put(8'h17, 8'hFF);
      put(8'h18, ADD); put(8'h19, 8'h80);
      put(8'h1A, 8'h5C);
      put(8'h1B, BRN); put(8'h1C, 8'h10);
      put(8'h1D, ADD); put(8'h1E, 8'h00);
      run_prog(30);

      // program 3: back-to-back adds, carry out, then a non-minus branch
      clear_mem();
      put(8'h10, ADD); put(8'h11, 8'h01);
      put(8'h12, ADD); put(8'h13, 8'h02);
      put(8'h14, ADD); put(8'h15, 8'h03);
      put(8'h16, ADD); put(8'h17, 8'hFE);
      put(8'h18, ADD); put(8'h19, 8'h7A);
      put(8'h1A, 8'hFF);
      put(8'h1B, BRN); put(8'h1C, 8'hF0);
      run_prog(30);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog act=hung exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule